// File: doc/BRIEF.md
# I2C Slave with Maskable Address Match

This block is a byte-level I2C target. It watches open-drain SCL and SDA lines, oversampled by the system clock, and shifts in the address byte that follows a START. It acknowledges the byte only when the upper seven bits pass its address match. The match uses a primary address register and a secondary register. A mode bit decides how the secondary register is read. With the mode bit cleared, its seven address bits act as a per-bit don't-care mask on the primary address. With the mode bit set, they are a second independent address.

After a match, the block moves data bytes in the direction given by bit 0 of the address byte. Each completed byte sets a data flag, which is also the interrupt output, and a hold flag. While the hold flag is set, the block keeps SCL low so that software can service it. Software releases the bus by writing the status register. In smart mode, any access to the data register also releases the bus. A receive-side ACK or NACK is taken from a control bit at the moment of release.

The controller has ten states:
- IDLE: the bus is free.
- ADDR: the address byte is being shifted in.
- ADDR_ACK: the slave drives the ACK for its address.
- RX_DATA: a written byte is being shifted in.
- RX_WAIT: SCL is held after a received byte.
- RX_ACK: the slave drives the chosen ACK or NACK.
- TX_DATA: a byte is shifted out.
- TX_ACKCHK: the master's acknowledge is sampled.
- TX_WAIT: SCL is held after a sent byte.
- SKIP: the address did not match, or the master NACKed; the slave waits for the next START.

The transitions are:
- START in any state goes to ADDR, and STOP in any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match, or to SKIP otherwise, at the eighth SCL fall.
- ADDR_ACK goes to TX_DATA or RX_DATA by direction.
- RX_DATA goes to RX_WAIT at the eighth fall.
- RX_WAIT goes to RX_ACK when the hold flag clears.
- RX_ACK goes back to RX_DATA.
- TX_DATA goes to TX_ACKCHK at the eighth fall.
- TX_ACKCHK goes to TX_WAIT.
- TX_WAIT goes to TX_DATA after a master ACK, or to SKIP after a NACK, once the hold flag clears.

Top module: `i2c_mask_slave`

## Requirements
- R1: After reset, every register reads zero, and irq, scl_oe and sda_oe are low.
- R2: With SEC bit 0 = 0 (mask mode), an address byte is ACKed (SDA low during the ninth clock) when, for every bit i of its bits 7:1, either SEC[i+1] is 1 or that bit equals PRIM[i+1]. Registers: CTRL=0, STAT=1, PRIM=2, SEC=3, DATA=4; PRIM and SEC hold address bits in positions 7:1.
- R3: With SEC bit 0 = 1 (pair mode), an address byte is ACKed only when its bits 7:1 equal PRIM[7:1] or SEC[7:1] exactly.
- R4: A mismatching address is NACKed. Following bytes are neither ACKed nor flagged, and SCL is not held, until the next START.
- R5: On a master write, after eight data bits the byte reads from DATA. STAT bit 0 (data flag, also irq) and STAT bit 1 (hold flag) are set, and scl_oe stays high while the hold flag is set.
- R6: The received byte is ACKed when CTRL bit 1 is 0 and NACKed when it is 1, using the value at the moment the hold flag clears.
- R7: On a master read, DATA is sent MSB first. After the master's acknowledge bit, both flags are set and SCL is held. STAT bit 3 records a master NACK (1), after which the slave releases SDA and stays idle.
- R8: With CTRL bit 0 = 0, writing STAT with bit 0 = 1 clears the data flag and with bit 1 = 1 clears the hold flag, which releases SCL. Accessing DATA leaves both flags unchanged.
- R9: With CTRL bit 0 = 1 (smart mode), any read or write of DATA clears both flags and starts the acknowledge given by CTRL bit 1.
- R10: A START seen mid-byte restarts the address phase with the bit count reset. A STOP seen mid-byte returns the slave to idle with no flag set.
- R11: STAT bit 2 shows bit 0 of the last matched address byte (1 = master read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Data flag |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with SYNC_STAGES = 3, one stage more than the default. This widens the gap between a line edge and the slave's reaction, so every SDA change must still land while SCL is low, including the ACK drive and hold release. A bus quarter-period of ten system clocks is long enough that hold, release and register accesses all fit inside a single low SCL phase. This lets the bench check the held line and the flag state between bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int DW   = 8;
    localparam int AW   = 7;
    localparam int RA_W = 3;

    localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
    localparam logic [RA_W-1:0] RA_STAT = 3'd1;
    localparam logic [RA_W-1:0] RA_PRIM = 3'd2;
    localparam logic [RA_W-1:0] RA_SEC  = 3'd3;
    localparam logic [RA_W-1:0] RA_DATA = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_RX_DATA, S_RX_WAIT,
        S_RX_ACK, S_TX_DATA, S_TX_ACKCHK, S_TX_WAIT, S_SKIP
    } state_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p[0] <= scl_in;
            sda_p[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_p[i] <= scl_p[i-1];
                sda_p[i] <= sda_p[i-1];
            end
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_addr_match.sv
module i2cm_addr_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] cand,
    input  logic [AW-1:0] prim,
    input  logic [AW-1:0] sec,
    input  logic          pair_mode,
    output logic          hit
);
    logic [AW-1:0] bit_ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_ok[i] = sec[i] | (cand[i] == prim[i]);
    end

    assign hit = pair_mode ? ((cand == prim) || (cand == sec)) : (&bit_ok);
endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            smart,
    output logic            nack_next,
    output logic [AW-1:0]   prim,
    output logic [AW-1:0]   sec,
    output logic            pair_mode,
    output logic [DW-1:0]   data_q,
    output logic            dflag,
    output logic            hold,
    output logic            data_acc,
    input  logic            bus_set_flags,
    input  logic            bus_cap_en,
    input  logic [DW-1:0]   bus_cap,
    input  logic            rw_set,
    input  logic            rw_val,
    input  logic            mnack_set,
    input  logic            mnack_val
);
    logic rw_q, mnack_q, clr_d, clr_h, stat_wr;

    assign data_acc = (reg_wr | reg_rd) && (reg_addr == RA_DATA);
    assign stat_wr  = reg_wr && (reg_addr == RA_STAT);
    assign clr_d    = (stat_wr && reg_wdata[0]) || (smart && data_acc);
    assign clr_h    = (stat_wr && reg_wdata[1]) || (smart && data_acc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smart     <= 1'b0;
            nack_next <= 1'b0;
            prim      <= '0;
            sec       <= '0;
            pair_mode <= 1'b0;
            data_q    <= '0;
            dflag     <= 1'b0;
            hold      <= 1'b0;
            rw_q      <= 1'b0;
            mnack_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                smart     <= reg_wdata[0];
                nack_next <= reg_wdata[1];
            end
            if (reg_wr && reg_addr == RA_PRIM) prim <= reg_wdata[DW-1:1];
            if (reg_wr && reg_addr == RA_SEC) begin
                sec       <= reg_wdata[DW-1:1];
                pair_mode <= reg_wdata[0];
            end
            if (bus_cap_en)                         data_q <= bus_cap;
            else if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
            if (bus_set_flags) begin
                dflag <= 1'b1;
                hold  <= 1'b1;
            end else begin
                if (clr_d) dflag <= 1'b0;
                if (clr_h) hold  <= 1'b0;
            end
            if (rw_set)    rw_q    <= rw_val;
            if (mnack_set) mnack_q <= mnack_val;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {6'b0, nack_next, smart};
            RA_STAT: reg_rdata = {4'b0, mnack_q, rw_q, hold, dflag};
            RA_PRIM: reg_rdata = {prim, 1'b0};
            RA_SEC:  reg_rdata = {sec, pair_mode};
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_mask_slave.sv
module i2c_mask_slave
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    input  logic            scl_in,
    output logic            scl_oe,
    input  logic            sda_in,
    output logic            sda_oe
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BYTE_END = CW'(DW);
    localparam logic [CW-1:0] TX_LAST  = CW'(DW - 1);

    state_t        state_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shreg_q, txsh_q;
    logic          rw_q, mnack_q, ackdrv_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic smart, nack_next, pair_mode, dflag, hold_q, data_acc, addr_hit;
    logic [AW-1:0] prim, sec;
    logic [DW-1:0] data_q;
    logic bus_set_flags, bus_cap_en, rw_set, mnack_set;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cm_addr_match #(.AW(AW)) u_match (
        .cand(shreg_q[DW-1:1]), .prim(prim), .sec(sec),
        .pair_mode(pair_mode), .hit(addr_hit)
    );

    i2cm_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smart(smart), .nack_next(nack_next), .prim(prim), .sec(sec),
        .pair_mode(pair_mode), .data_q(data_q), .dflag(dflag), .hold(hold_q),
        .data_acc(data_acc), .bus_set_flags(bus_set_flags),
        .bus_cap_en(bus_cap_en), .bus_cap(shreg_q), .rw_set(rw_set),
        .rw_val(shreg_q[0]), .mnack_set(mnack_set), .mnack_val(mnack_q)
    );

    // State register and bus datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            shreg_q  <= '0;
            txsh_q   <= '0;
            rw_q     <= 1'b0;
            mnack_q  <= 1'b0;
            ackdrv_q <= 1'b0;
        end else if (stop_det) begin
            state_q <= S_IDLE;
        end else if (start_det) begin
            state_q <= S_ADDR;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                S_ADDR: begin
                    if (scl_rise && cnt_q != BYTE_END) begin
                        shreg_q <= {shreg_q[DW-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == BYTE_END) begin
                        if (addr_hit) begin
                            state_q <= S_ADDR_ACK;
                            rw_q    <= shreg_q[0];
                        end else begin
                            state_q <= S_SKIP;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            state_q <= S_TX_DATA;
                            txsh_q  <= data_q;
                        end else begin
                            state_q <= S_RX_DATA;
                        end
                    end
                end
                S_RX_DATA: begin
                    if (scl_rise && cnt_q != BYTE_END) begin
                        shreg_q <= {shreg_q[DW-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == BYTE_END) begin
                        state_q <= S_RX_WAIT;
                    end
                end
                S_RX_WAIT: begin
                    if (!hold_q) begin
                        ackdrv_q <= ~nack_next;
                        state_q  <= S_RX_ACK;
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        state_q <= S_RX_DATA;
                        cnt_q   <= '0;
                    end
                end
                S_TX_DATA: begin
                    if (scl_fall) begin
                        if (cnt_q == TX_LAST) begin
                            state_q <= S_TX_ACKCHK;
                        end else begin
                            txsh_q <= {txsh_q[DW-2:0], 1'b0};
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                end
                S_TX_ACKCHK: begin
                    if (scl_rise) mnack_q <= sda_s;
                    if (scl_fall) state_q <= S_TX_WAIT;
                end
                S_TX_WAIT: begin
                    if (!hold_q) begin
                        if (!mnack_q) begin
                            state_q <= S_TX_DATA;
                            txsh_q  <= data_q;
                            cnt_q   <= '0;
                        end else begin
                            state_q <= S_SKIP;
                        end
                    end
                end
                S_IDLE, S_SKIP: ;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs and events toward the register file
    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        unique case (state_q)
            S_ADDR_ACK: sda_oe = 1'b1;
            S_RX_ACK:   sda_oe = ackdrv_q;
            S_TX_DATA:  sda_oe = ~txsh_q[DW-1];
            S_RX_WAIT,
            S_TX_WAIT:  scl_oe = 1'b1;
            default: ;
        endcase
        bus_cap_en    = (state_q == S_RX_DATA) && scl_fall && (cnt_q == BYTE_END)
                        && !start_det && !stop_det;
        mnack_set     = (state_q == S_TX_ACKCHK) && scl_fall && !start_det && !stop_det;
        bus_set_flags = bus_cap_en || mnack_set;
        rw_set        = (state_q == S_ADDR) && scl_fall && (cnt_q == BYTE_END)
                        && addr_hit && !start_det && !stop_det;
        irq           = dflag;
    end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input state_t state_q,
    input logic   scl_s,
    input logic   scl_oe,
    input logic   sda_oe,
    input logic   hold_q,
    input logic   smart,
    input logic   data_acc,
    input logic   addr_hit
);
    // R2 and R3: the address is acknowledged only after a match
    p_ack_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_ADDR_ACK) |-> $past(addr_hit));

    // R4: an unaddressed slave drives neither line
    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SKIP) |-> (!sda_oe && !scl_oe));

    // R5: a newly raised hold flag stretches the clock
    p_hold_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> scl_oe);

    // R9: smart access during a hold clears it
    p_smart_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && smart && data_acc) |=> !hold_q);

    // R10: SDA drive never moves while SCL is high
    p_sda_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind i2c_mask_slave i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .scl_s(scl_s),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .hold_q(hold_q), .smart(smart),
    .data_acc(data_acc), .addr_hit(addr_hit)
);

// File: tb/i2c_mask_slave_tb_top.sv
module i2c_mask_slave_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_line, sda_line;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_mask_slave #(.SYNC_STAGES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_in(scl_line), .scl_oe(scl_oe),
        .sda_in(sda_line), .sda_oe(sda_oe)
    );

    // {prim[6:0], sec[7:0], address byte, expect ACK}
    localparam logic [23:0] VECS [10] = '{
        {7'h50, 8'h00, 8'hA0, 1'b1},
        {7'h50, 8'h00, 8'hA2, 1'b0},
        {7'h50, 8'h06, 8'hA2, 1'b1},
        {7'h50, 8'h06, 8'hA6, 1'b1},
        {7'h50, 8'h06, 8'hA8, 1'b0},
        {7'h50, 8'h47, 8'h46, 1'b1},
        {7'h50, 8'h47, 8'hA0, 1'b1},
        {7'h50, 8'h47, 8'hA2, 1'b0},
        {7'h50, 8'hFE, 8'h0E, 1'b1},
        {7'h2A, 8'h00, 8'h54, 1'b1}
    };

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b;
        tk(Q);
        m_scl = 1'b1;
        while (!scl_line) tk(1);
        tk(Q);
        r = sda_line;
        m_scl = 1'b0;
        tk(Q);
    endtask

    task automatic m_start();
        m_sda = 1'b1; tk(Q);
        m_scl = 1'b1; tk(Q);
        m_sda = 1'b0; tk(Q);
        m_scl = 1'b0; tk(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tk(Q);
        m_scl = 1'b1; tk(Q);
        m_sda = 1'b1; tk(Q);
    endtask

    task automatic m_send8(input logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    endtask

    task automatic m_recv8(output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic       r;
        tk(3);
        rst_n = 1'b1;
        tk(3);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reg", {24'b0, v}, 32'h0);
        end
        chk("R1 lines", {29'b0, irq, scl_oe, sda_oe}, 32'h0);

        // R2 R3 R4: address match table
        for (int k = 0; k < 10; k++) begin
            wr(3'd2, {VECS[k][23:17], 1'b0});
            wr(3'd3, VECS[k][16:9]);
            m_start();
            m_send8(VECS[k][8:1]);
            m_bit(1'b1, r);
            chk(VECS[k][9] ? "R3 match" : "R2 match", {31'b0, ~r}, {31'b0, VECS[k][0]});
            m_stop();
        end

        // R5 R6 R8: master write, non-smart
        wr(3'd2, 8'hA0);
        wr(3'd3, 8'h00);
        m_start();
        m_send8(8'hA0);
        m_bit(1'b1, r);
        chk("R5 addr ack", {31'b0, r}, 32'h0);
        m_send8(8'h3C);
        rd(3'd1, v);
        chk("R5 stat", {24'b0, v}, 32'h03);
        chk("R5 irq/hold", {30'b0, irq, scl_oe}, 32'h3);
        rd(3'd4, v);
        chk("R5 data", {24'b0, v}, 32'h3C);
        rd(3'd1, v);
        chk("R8 data access keeps flags", {24'b0, v}, 32'h03);
        wr(3'd1, 8'h03);
        tk(2);
        chk("R8 release", {30'b0, irq, scl_oe}, 32'h0);
        m_bit(1'b1, r);
        chk("R6 ack", {31'b0, r}, 32'h0);
        wr(3'd0, 8'h02);
        m_send8(8'h81);
        wr(3'd1, 8'h03);
        m_bit(1'b1, r);
        chk("R6 nack", {31'b0, r}, 32'h1);
        m_stop();
        wr(3'd0, 8'h00);

        // R9: smart mode
        wr(3'd0, 8'h01);
        m_start();
        m_send8(8'hA0);
        m_bit(1'b1, r);
        m_send8(8'h5A);
        rd(3'd1, v);
        chk("R9 flags set", {24'b0, v}, 32'h03);
        rd(3'd4, v);
        chk("R9 data", {24'b0, v}, 32'h5A);
        rd(3'd1, v);
        chk("R9 cleared", {24'b0, v}, 32'h00);
        chk("R9 scl free", {31'b0, scl_oe}, 32'h0);
        m_bit(1'b1, r);
        chk("R9 ack", {31'b0, r}, 32'h0);
        m_stop();
        wr(3'd0, 8'h00);

        // R7 R11: master read
        wr(3'd4, 8'hC5);
        m_start();
        m_send8(8'hA1);
        m_bit(1'b1, r);
        chk("R7 addr ack", {31'b0, r}, 32'h0);
        rd(3'd1, v);
        chk("R11 dir", {24'b0, v}, 32'h04);
        m_recv8(v);
        chk("R7 byte0", {24'b0, v}, 32'hC5);
        m_bit(1'b0, r);
        rd(3'd1, v);
        chk("R7 flags after ack", {24'b0, v}, 32'h07);
        chk("R7 hold", {31'b0, scl_oe}, 32'h1);
        wr(3'd4, 8'h3E);
        wr(3'd1, 8'h03);
        m_recv8(v);
        chk("R7 byte1", {24'b0, v}, 32'h3E);
        m_bit(1'b1, r);
        rd(3'd1, v);
        chk("R7 nack seen", {24'b0, v}, 32'h0F);
        wr(3'd1, 8'h03);
        tk(3);
        chk("R7 idle after nack", {30'b0, scl_oe, sda_oe}, 32'h0);
        m_stop();

        // R4: mismatch ignores data
        m_start();
        m_send8(8'hB0);
        m_bit(1'b1, r);
        chk("R4 addr nack", {31'b0, r}, 32'h1);
        m_send8(8'hFF);
        m_bit(1'b1, r);
        chk("R4 data nack", {31'b0, r}, 32'h1);
        rd(3'd1, v);
        chk("R4 no flags", {24'b0, v & 8'h03}, 32'h0);
        chk("R4 lines", {30'b0, irq, scl_oe}, 32'h0);
        m_stop();

        // R10: repeated START and STOP mid-byte
        m_start();
        m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
        m_start();
        m_send8(8'hA0);
        m_bit(1'b1, r);
        chk("R10 restart ack", {31'b0, r}, 32'h0);
        m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b1, r); m_bit(1'b0, r);
        m_stop();
        tk(3);
        rd(3'd1, v);
        chk("R10 stop no flag", {24'b0, v & 8'h03}, 32'h0);
        chk("R10 lines", {30'b0, scl_oe, sda_oe}, 32'h0);
        m_start();
        m_send8(8'hA0);
        m_bit(1'b1, r);
        chk("R10 after stop ack", {31'b0, r}, 32'h0);
        m_stop();

        finish_run();
    end
endmodule